// File: doc/BRIEF.md
# Display Host Bus Port

This block is the microprocessor side of a dot-matrix character display. It sits on a byte-wide bidirectional data bus with chip select, write strobe, read strobe, a flash-bank select and five address lines. It decodes each access into one of five storage areas: an eight-digit character store, a per-digit flash bit store, a four-bit pointer that selects a user glyph, the pattern store holding sixteen user glyphs of seven five-dot rows, and an attribute (control) register. Every area can be written and read back. The stored contents leave the block as flat vectors for the scan engine, which is outside this block.

The bus pins are treated as synchronous to `clk`. A write commits on the clock edge that first sees the write strobe high again after it was low, while chip select is low. A read is combinational: the bus is driven while chip select and read strobe are both low. Two housekeeping sequences make the host wait. The first runs for a few clocks after reset is released. The second runs while a clear command fills the character store with blanks and empties the flash bits. The `ready_o` flag is low during both, and bus accesses made then are ignored.

Top module: `disp_host_port`

## Requirements
- R1: Area select. With `bank_n`=0 the flash bits are addressed. With `bank_n`=1, `addr[4:3]` selects the area: 00 glyph pointer, 01 glyph pattern row, 11 character store, 10 attribute register.
- R2: Flash bits. `addr[2:0]` picks the digit and only data bit 0 is stored, whatever `addr[4:3]` holds. A read returns the bit in bit 0 with zeros above it. `flash_o[d]` is digit d.
- R3: The glyph pointer stores data bits 3..0, and bits 7..4 are ignored. A read returns the pointer with zeros in bits 7..4. The pointer changes only on a write to it.
- R4: Pattern rows. `addr[2:0]` = 0..6 picks a row of the glyph named by the pointer, and data bits 4..0 are the dots. Writes to row 7 are ignored and reads of row 7 return 0. Row r of glyph g appears at `udc_pat_o[(g*7+r)*5 +: 5]`.
- R5: The character store keeps all eight data bits of each digit. Bit 7 tags a user-glyph index in bits 3..0, and with bit 7 clear the low seven bits are a font code. `addr[2]` is the digit MSB, and digit d (digit 0 leftmost) appears at `chars_o[8*d +: 8]`.
- R6: A write commits on the first clock that sees `wr_n` high after it was low, and only while `cs_n` is low. With `cs_n` high a strobe has no effect.
- R7: `dbus` is driven only while `cs_n` and `rd_n` are both low.
- R8: Attribute bits: 2..0 brightness code (`bright_o`), 3 flash enable, 4 blink enable, 6 self-test start, 7 clear. Writes to bit 5 are ignored, and a read returns `selftest_pass` in bit 5.
- R9: Reset sets every digit to 0x20 and clears the flash bits and the attribute register. The glyph pointer and the pattern store keep their contents.
- R10: After reset is released, `ready_o` stays low for three clocks, and accesses made then are dropped.
- R11: Writing attribute bit 7 = 1 fills the character store with 0x20 and the flash bits with 0 within three clocks. Bit 7 then returns to 0 by itself. The other attribute bits, the glyph pointer and the pattern store are kept. `ready_o` is low until the clear has finished, and accesses made then are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, low active |
| wr_n | input | 1 | Write strobe, commits on its rising transition |
| rd_n | input | 1 | Read strobe, low active |
| bank_n | input | 1 | Low selects the flash bits |
| addr | input | 5 | Area select (4:3) and digit or row index (2:0) |
| dbus | inout | 8 | Bidirectional data bus |
| selftest_pass | input | 1 | Self-test result from the scan engine |
| chars_o | output | 64 | Character store, digit d at bits 8d+7..8d |
| flash_o | output | 8 | Flash bit per digit |
| udc_sel_o | output | 4 | Glyph pointer |
| udc_pat_o | output | 560 | Glyph patterns |
| bright_o | output | 3 | Brightness code |
| flash_en_o | output | 1 | Flash enable |
| blink_en_o | output | 1 | Blink enable |
| selftest_go_o | output | 1 | Self-test start |
| ready_o | output | 1 | Host may access the bus |

## Verification
On every cycle the assertions check the clear sequence: a blank character store and empty flash bits after each clear cycle, with `ready_o` held low during the clear. They also check that the glyph pointer holds its value when it is not being written, that reads of pattern row 7 return zero, that the self-test bit comes from its input, and that the character store stays frozen while the post-reset wait holds the bus off. Only the directed scenarios can show the area decode and its read-back formats, which data bits each area ignores, the position of each digit and row in the output vectors, that a strobe with chip select high does nothing, and that reset and clear both leave the glyph storage intact.

// File: rtl/disp_host_pkg.sv
package disp_host_pkg;
  localparam int DIGITS_DEF    = 8;
  localparam int CODE_W_DEF    = 8;
  localparam int UDC_CHARS_DEF = 16;
  localparam int UDC_ROWS_DEF  = 7;
  localparam int UDC_COLS_DEF  = 5;
  localparam int BUSY_CYC_DEF  = 3;
  localparam logic [7:0] BLANK_CODE = 8'h20;

  typedef enum logic [2:0] {
    AREA_FLASH = 3'd0,
    AREA_UPTR  = 3'd1,
    AREA_UROW  = 3'd2,
    AREA_CHAR  = 3'd3,
    AREA_ATTR  = 3'd4
  } area_e;
endpackage

// File: rtl/hb_decode.sv
module hb_decode
  import disp_host_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       wr_n,
  input  logic       rd_n,
  input  logic       bank_n,
  input  logic [1:0] area_sel,
  input  logic       ready,
  output area_e      area,
  output logic       wr_fire,
  output logic       rd_act
);
  logic wr_q, wr_d;

  always_comb begin
    if (!bank_n) area = AREA_FLASH;
    else begin
      unique case (area_sel)
        2'b00:   area = AREA_UPTR;
        2'b01:   area = AREA_UROW;
        2'b11:   area = AREA_CHAR;
        default: area = AREA_ATTR;
      endcase
    end
  end

  assign wr_d    = wr_n;
  assign wr_fire = ready && !cs_n && wr_n && !wr_q;
  assign rd_act  = ready && !cs_n && !rd_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_q <= 1'b1;
    else        wr_q <= wr_d;
  end
endmodule

// File: rtl/hb_glyph_store.sv
module hb_glyph_store
  import disp_host_pkg::*;
#(
  parameter int DIGITS = DIGITS_DEF,
  parameter int CODE_W = CODE_W_DEF,
  localparam int DIG_W = $clog2(DIGITS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_fire,
  input  area_e                    area,
  input  logic [DIG_W-1:0]         dig,
  input  logic [CODE_W-1:0]        wdata,
  input  logic                     wipe,
  output logic [DIGITS*CODE_W-1:0] chars_o,
  output logic [DIGITS-1:0]        flash_o,
  output logic [CODE_W-1:0]        rd_char,
  output logic                     rd_flash
);
  localparam logic [CODE_W-1:0] BLANK = CODE_W'(BLANK_CODE);

  logic [DIGITS-1:0][CODE_W-1:0] char_q, char_d;
  logic [DIGITS-1:0]             flash_q, flash_d;

  always_comb begin
    char_d  = char_q;
    flash_d = flash_q;
    if (wipe) begin
      char_d  = {DIGITS{BLANK}};
      flash_d = '0;
    end else if (wr_fire && area == AREA_CHAR) begin
      char_d[dig] = wdata;
    end else if (wr_fire && area == AREA_FLASH) begin
      flash_d[dig] = wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      char_q  <= {DIGITS{BLANK}};
      flash_q <= '0;
    end else begin
      char_q  <= char_d;
      flash_q <= flash_d;
    end
  end

  for (genvar g = 0; g < DIGITS; g++) begin : g_flat
    assign chars_o[g*CODE_W +: CODE_W] = char_q[g];
  end

  assign flash_o  = flash_q;
  assign rd_char  = char_q[dig];
  assign rd_flash = flash_q[dig];
endmodule

// File: rtl/hb_udc_store.sv
module hb_udc_store
  import disp_host_pkg::*;
#(
  parameter int UDC_CHARS = UDC_CHARS_DEF,
  parameter int UDC_ROWS  = UDC_ROWS_DEF,
  parameter int UDC_COLS  = UDC_COLS_DEF,
  localparam int UIDX_W   = $clog2(UDC_CHARS),
  localparam int ROW_W    = $clog2(UDC_ROWS + 1),
  localparam int PAT_W    = UDC_CHARS * UDC_ROWS * UDC_COLS
) (
  input  logic                clk,
  input  logic                wr_fire,
  input  area_e               area,
  input  logic [ROW_W-1:0]    row,
  input  logic [UIDX_W-1:0]   sel_wdata,
  input  logic [UDC_COLS-1:0] dots_wdata,
  output logic [UIDX_W-1:0]   udc_sel_o,
  output logic [PAT_W-1:0]    udc_pat_o,
  output logic [UDC_COLS-1:0] rd_row
);
  logic [UIDX_W-1:0]   sel_q, sel_d;
  logic                sel_en;
  logic [UDC_COLS-1:0] pat_q [UDC_CHARS][UDC_ROWS];
  logic                row_ok, row_we;
  logic [ROW_W-1:0]    row_idx;

  assign sel_en  = wr_fire && area == AREA_UPTR;
  assign sel_d   = sel_en ? sel_wdata : sel_q;
  assign row_ok  = row < ROW_W'(UDC_ROWS);
  assign row_idx = row_ok ? row : '0;
  assign row_we  = wr_fire && area == AREA_UROW && row_ok;

  always_ff @(posedge clk) begin
    sel_q <= sel_d;
  end

  always_ff @(posedge clk) begin
    if (row_we) pat_q[sel_q][row_idx] <= dots_wdata;
  end

  for (genvar c = 0; c < UDC_CHARS; c++) begin : g_chr
    for (genvar r = 0; r < UDC_ROWS; r++) begin : g_row
      assign udc_pat_o[(c*UDC_ROWS + r)*UDC_COLS +: UDC_COLS] = pat_q[c][r];
    end
  end

  assign udc_sel_o = sel_q;
  assign rd_row    = row_ok ? pat_q[sel_q][row_idx] : '0;
endmodule

// File: rtl/hb_attr_seq.sv
module hb_attr_seq
  import disp_host_pkg::*;
#(
  parameter int BUSY_CYC = BUSY_CYC_DEF,
  localparam int CNT_W   = $clog2(BUSY_CYC + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_fire,
  input  area_e      area,
  input  logic [7:0] wdata,
  input  logic       selftest_pass,
  output logic [7:0] rd_attr,
  output logic [2:0] bright_o,
  output logic       flash_en_o,
  output logic       blink_en_o,
  output logic       selftest_go_o,
  output logic       wipe,
  output logic       ready
);
  localparam int B_CLR   = 7;
  localparam int B_GO    = 6;
  localparam int B_BLINK = 4;
  localparam int B_FLASH = 3;

  logic             clr_q, clr_d, go_q, go_d, blink_q, blink_d, flen_q, flen_d;
  logic [2:0]       br_q, br_d;
  logic [CNT_W-1:0] busy_q, busy_d;
  logic             attr_we;

  assign attr_we = wr_fire && area == AREA_ATTR;

  always_comb begin
    clr_d   = clr_q;
    go_d    = go_q;
    blink_d = blink_q;
    flen_d  = flen_q;
    br_d    = br_q;
    busy_d  = busy_q;
    if (busy_q != '0) busy_d = busy_q - 1'b1;
    if (clr_q && busy_q == CNT_W'(1)) clr_d = 1'b0;
    if (attr_we) begin
      clr_d   = wdata[B_CLR];
      go_d    = wdata[B_GO];
      blink_d = wdata[B_BLINK];
      flen_d  = wdata[B_FLASH];
      br_d    = wdata[2:0];
      if (wdata[B_CLR]) busy_d = CNT_W'(BUSY_CYC);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_q   <= 1'b0;
      go_q    <= 1'b0;
      blink_q <= 1'b0;
      flen_q  <= 1'b0;
      br_q    <= '0;
      busy_q  <= CNT_W'(BUSY_CYC);
    end else begin
      clr_q   <= clr_d;
      go_q    <= go_d;
      blink_q <= blink_d;
      flen_q  <= flen_d;
      br_q    <= br_d;
      busy_q  <= busy_d;
    end
  end

  assign rd_attr       = {clr_q, go_q, selftest_pass, blink_q, flen_q, br_q};
  assign bright_o      = br_q;
  assign flash_en_o    = flen_q;
  assign blink_en_o    = blink_q;
  assign selftest_go_o = go_q;
  assign wipe          = clr_q;
  assign ready         = busy_q == '0;
endmodule

// File: rtl/disp_host_port.sv
module disp_host_port
  import disp_host_pkg::*;
#(
  parameter int DIGITS    = DIGITS_DEF,
  parameter int UDC_CHARS = UDC_CHARS_DEF,
  parameter int UDC_ROWS  = UDC_ROWS_DEF,
  parameter int UDC_COLS  = UDC_COLS_DEF,
  parameter int BUSY_CYC  = BUSY_CYC_DEF,
  localparam int CODE_W   = 8,
  localparam int DIG_W    = $clog2(DIGITS),
  localparam int UIDX_W   = $clog2(UDC_CHARS),
  localparam int ROW_W    = $clog2(UDC_ROWS + 1),
  localparam int PAT_W    = UDC_CHARS * UDC_ROWS * UDC_COLS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cs_n,
  input  logic                     wr_n,
  input  logic                     rd_n,
  input  logic                     bank_n,
  input  logic [4:0]               addr,
  inout  wire  [CODE_W-1:0]        dbus,
  input  logic                     selftest_pass,
  output logic [DIGITS*CODE_W-1:0] chars_o,
  output logic [DIGITS-1:0]        flash_o,
  output logic [UIDX_W-1:0]        udc_sel_o,
  output logic [PAT_W-1:0]         udc_pat_o,
  output logic [2:0]               bright_o,
  output logic                     flash_en_o,
  output logic                     blink_en_o,
  output logic                     selftest_go_o,
  output logic                     ready_o
);
  area_e               area;
  logic                wr_fire, rd_act, wipe;
  logic [CODE_W-1:0]   rd_char, rd_attr, rdata;
  logic                rd_flash;
  logic [UDC_COLS-1:0] rd_row;

  hb_decode u_dec (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .bank_n(bank_n), .area_sel(addr[4:3]), .ready(ready_o),
    .area(area), .wr_fire(wr_fire), .rd_act(rd_act)
  );

  hb_glyph_store #(.DIGITS(DIGITS), .CODE_W(CODE_W)) u_glyph (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .area(area),
    .dig(addr[DIG_W-1:0]), .wdata(dbus), .wipe(wipe),
    .chars_o(chars_o), .flash_o(flash_o), .rd_char(rd_char), .rd_flash(rd_flash)
  );

  hb_udc_store #(.UDC_CHARS(UDC_CHARS), .UDC_ROWS(UDC_ROWS), .UDC_COLS(UDC_COLS)) u_udc (
    .clk(clk), .wr_fire(wr_fire), .area(area), .row(addr[ROW_W-1:0]),
    .sel_wdata(dbus[UIDX_W-1:0]), .dots_wdata(dbus[UDC_COLS-1:0]),
    .udc_sel_o(udc_sel_o), .udc_pat_o(udc_pat_o), .rd_row(rd_row)
  );

  hb_attr_seq #(.BUSY_CYC(BUSY_CYC)) u_attr (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .area(area), .wdata(dbus),
    .selftest_pass(selftest_pass), .rd_attr(rd_attr), .bright_o(bright_o),
    .flash_en_o(flash_en_o), .blink_en_o(blink_en_o),
    .selftest_go_o(selftest_go_o), .wipe(wipe), .ready(ready_o)
  );

  always_comb begin
    unique case (area)
      AREA_FLASH: rdata = {{(CODE_W-1){1'b0}}, rd_flash};
      AREA_UPTR:  rdata = {{(CODE_W-UIDX_W){1'b0}}, udc_sel_o};
      AREA_UROW:  rdata = {{(CODE_W-UDC_COLS){1'b0}}, rd_row};
      AREA_CHAR:  rdata = rd_char;
      default:    rdata = rd_attr;
    endcase
  end

  assign dbus = rd_act ? rdata : {CODE_W{1'bz}};
endmodule

// File: rtl/disp_host_port_chk.sv
module disp_host_port_chk
  import disp_host_pkg::*;
#(
  parameter int DIGITS = 8,
  parameter int UIDX_W = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_fire,
  input logic                rd_act,
  input logic                wipe,
  input area_e               area,
  input logic [4:0]          addr,
  input logic [7:0]          dbus,
  input logic                selftest_pass,
  input logic [DIGITS*8-1:0] chars_o,
  input logic [DIGITS-1:0]   flash_o,
  input logic [UIDX_W-1:0]   udc_sel_o,
  input logic                ready_o
);
  // R11
  clear_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> (chars_o == {DIGITS{BLANK_CODE}} && flash_o == '0));

  // R11
  clear_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |-> !ready_o);

  // R3
  uptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_fire && area == AREA_UPTR) |=> $stable(udc_sel_o));

  // R4
  row7_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && area == AREA_UROW && addr[2:0] == 3'd7) |-> dbus == 8'h00);

  // R8
  pass_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && area == AREA_ATTR) |-> dbus[5] == selftest_pass);

  // R10
  busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_o && !wipe) |=> $stable(chars_o));
endmodule

bind disp_host_port disp_host_port_chk #(.DIGITS(DIGITS), .UIDX_W(UIDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .rd_act(rd_act), .wipe(wipe),
  .area(area), .addr(addr), .dbus(dbus), .selftest_pass(selftest_pass),
  .chars_o(chars_o), .flash_o(flash_o), .udc_sel_o(udc_sel_o), .ready_o(ready_o)
);

// File: tb/disp_host_port_test.sv
module disp_host_port_test;
  logic clk = 1'b0;
  logic rst_n, cs_n, wr_n, rd_n, bank_n, st_pass;
  logic [4:0] addr;
  logic [7:0] drv_val;
  logic       drv_en;
  wire  [7:0] dbus;
  logic [63:0]  chars_o;
  logic [7:0]   flash_o;
  logic [3:0]   udc_sel_o;
  logic [559:0] udc_pat_o;
  logic [2:0]   bright_o;
  logic flash_en_o, blink_en_o, selftest_go_o, ready_o;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  assign dbus = drv_en ? drv_val : 8'hzz;

  disp_host_port uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .bank_n(bank_n), .addr(addr), .dbus(dbus), .selftest_pass(st_pass),
    .chars_o(chars_o), .flash_o(flash_o), .udc_sel_o(udc_sel_o),
    .udc_pat_o(udc_pat_o), .bright_o(bright_o), .flash_en_o(flash_en_o),
    .blink_en_o(blink_en_o), .selftest_go_o(selftest_go_o), .ready_o(ready_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // All bus tasks start and end on a falling clock edge.
  task automatic wr_bus(input logic fl, input logic [4:0] a, input logic [7:0] d,
                        input logic cs_val = 1'b0);
    bank_n = fl; addr = a; drv_val = d; drv_en = 1'b1; cs_n = cs_val; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); cs_n = 1'b1; drv_en = 1'b0;
  endtask

  task automatic rd_bus(input logic fl, input logic [4:0] a, output logic [7:0] d);
    bank_n = fl; addr = a; cs_n = 1'b0; rd_n = 1'b0;
    #2 d = dbus;
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [7:0] v;
    rst_n = 1'b0; idle(3);
    rst_n = 1'b1; idle(2);
    chk("R10 ready low after release", ready_o, 1'b0);
    idle(1);
    chk("R10 ready high after 3 clocks", ready_o, 1'b1);
    chk("R9 chars blank", chars_o, 64'h2020202020202020 & 32'hFFFFFFFF);
    chk("R9 chars blank high", chars_o[63:32], 32'h20202020);
    chk("R9 flash cleared", flash_o, 8'h00);
    st_pass = 1'b0;
    rd_bus(1'b1, 5'b10_000, v);
    chk("R9 attr cleared", v, 8'h00);
  endtask

  task automatic t_chars();
    logic [7:0] v;
    wr_bus(1'b1, 5'b11_000, 8'h53);
    wr_bus(1'b1, 5'b11_100, 8'h85);
    wr_bus(1'b1, 5'b11_111, 8'h45);
    chk("R5 digit0 at low byte", chars_o[7:0], 8'h53);
    chk("R5 addr2 is digit MSB, user tag kept", chars_o[39:32], 8'h85);
    rd_bus(1'b1, 5'b11_111, v);
    chk("R5 read digit7", v, 8'h45);
    rd_bus(1'b1, 5'b11_100, v);
    chk("R1 char area read", v, 8'h85);
    wr_bus(1'b1, 5'b11_000, 8'h77, 1'b1);
    chk("R6 no commit with cs high", chars_o[7:0], 8'h53);
  endtask

  task automatic t_flash();
    logic [7:0] v;
    wr_bus(1'b0, 5'b11_010, 8'hFF);
    chk("R2 flash digit2 set", flash_o, 8'h04);
    wr_bus(1'b0, 5'b01_110, 8'hFE);
    chk("R2 only D0 used", flash_o, 8'h04);
    rd_bus(1'b0, 5'b00_010, v);
    chk("R2 read ignores addr4:3", v, 8'h01);
  endtask

  task automatic t_udc();
    logic [7:0] v;
    logic [7:0] rows [7] = '{8'hEE, 8'h11, 8'h31, 8'h1F, 8'hF1, 8'h11, 8'h11};
    wr_bus(1'b1, 5'b00_000, 8'hF5);
    chk("R3 pointer low nibble", udc_sel_o, 4'h5);
    rd_bus(1'b1, 5'b00_111, v);
    chk("R3 pointer read zero-extended", v, 8'h05);
    for (int r = 0; r < 7; r++) wr_bus(1'b1, {2'b01, 3'(r)}, rows[r]);
    for (int r = 0; r < 7; r++) begin
      rd_bus(1'b1, {2'b01, 3'(r)}, v);
      chk("R4 row readback", v, {3'b0, rows[r][4:0]});
    end
    chk("R4 row3 of glyph5 in output", udc_pat_o[(5*7+3)*5 +: 5], 5'h1F);
    chk("R4 row0 of glyph5 in output", udc_pat_o[(5*7)*5 +: 5], 5'h0E);
    wr_bus(1'b1, 5'b01_111, 8'h1F);
    rd_bus(1'b1, 5'b01_111, v);
    chk("R4 row7 reads zero", v, 8'h00);
    chk("R4 row7 write leaves row6", udc_pat_o[(5*7+6)*5 +: 5], 5'h11);
  endtask

  task automatic t_attr();
    logic [7:0] v;
    wr_bus(1'b1, 5'b10_000, 8'h7F);
    chk("R8 brightness", bright_o, 3'd7);
    chk("R8 flash enable", flash_en_o, 1'b1);
    chk("R8 blink enable", blink_en_o, 1'b1);
    chk("R8 selftest start", selftest_go_o, 1'b1);
    st_pass = 1'b0;
    rd_bus(1'b1, 5'b10_000, v);
    chk("R8 bit5 write ignored", v, 8'h5F);
    st_pass = 1'b1;
    rd_bus(1'b1, 5'b10_000, v);
    chk("R8 bit5 reads input", v, 8'h7F);
    st_pass = 1'b0;
  endtask

  task automatic t_bus_float();
    // Digit 0 holds 0x53; a wrongful drive of it would disturb the bench value.
    bank_n = 1'b1; addr = 5'b11_000; cs_n = 1'b1; rd_n = 1'b0;
    drv_val = 8'h2C; drv_en = 1'b1;
    #2 chk("R7 no drive with cs high", dbus, 8'h2C);
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b1;
    #2 chk("R7 no drive with rd high", dbus, 8'h2C);
    @(negedge clk); cs_n = 1'b1; drv_en = 1'b0;
  endtask

  task automatic t_clear();
    logic [7:0] v;
    wr_bus(1'b1, 5'b10_000, 8'h8B);
    chk("R11 ready low during clear", ready_o, 1'b0);
    wr_bus(1'b1, 5'b00_000, 8'h09);
    idle(2);
    chk("R11 ready back", ready_o, 1'b1);
    chk("R11 chars blank", chars_o[31:0], 32'h20202020);
    chk("R11 chars blank high", chars_o[63:32], 32'h20202020);
    chk("R11 flash cleared", flash_o, 8'h00);
    rd_bus(1'b1, 5'b10_000, v);
    chk("R11 clear bit self-resets, others kept", v, 8'h0B);
    rd_bus(1'b1, 5'b00_000, v);
    chk("R11 write during clear dropped", v, 8'h05);
    chk("R11 patterns kept", udc_pat_o[(5*7+3)*5 +: 5], 5'h1F);
  endtask

  task automatic t_reset_keeps();
    logic [7:0] v;
    wr_bus(1'b0, 5'b00_001, 8'h01);
    rst_n = 1'b0; idle(2);
    rst_n = 1'b1;
    wr_bus(1'b1, 5'b00_000, 8'h0C);
    idle(2);
    rd_bus(1'b1, 5'b00_000, v);
    chk("R10 write during wait dropped, R9 pointer kept", v, 8'h05);
    chk("R9 patterns kept", udc_pat_o[(5*7+3)*5 +: 5], 5'h1F);
    chk("R9 flash cleared", flash_o, 8'h00);
    chk("R9 brightness cleared", bright_o, 3'd0);
    chk("R9 chars blank", chars_o[7:0], 8'h20);
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1; bank_n = 1'b1;
    addr = '0; drv_val = '0; drv_en = 1'b0; st_pass = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_chars();
    t_flash();
    t_udc();
    t_attr();
    t_bus_float();
    t_clear();
    t_reset_keeps();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog: got hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule